// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps a 32-bit count of seconds. The counter and its one-second divider run on a slow 32.768 kHz clock. Software reaches the block from a faster bus clock through a plain register port with address, write enable, write data and read data. A fixed divider in the slow domain produces one tick every `DIV` slow cycles, which is 32768 by default. Each tick advances the counter. The incremented value is then compared with an alarm register.

Two sticky flags record events. One sets on every tick. The other sets when the incremented count equals the alarm value. Each flag has its own enable, and the interrupt output is the OR of the enabled flags.

Software writes to the counter pass through a toggle handshake into the slow domain. While a write is in flight, a pending bit is visible to software and further counter writes are dropped. Counter reads come from a bus-domain copy. That copy is refreshed only after the slow side signals that the counter has settled, so a read never returns a half-updated value. The counter and alarm values survive reset.

Top module: `sec_alarm_ctr`

## Requirements
- R1: The counter increases by exactly one on the slow edge that ends a tick cycle. It keeps its value on every other slow edge unless a load occurs. The count wraps from all ones to zero.
- R2: On a tick, the alarm flag (STATUS bit 0) sets when the incremented count equals ALARM (address 1). A count that merely stays equal to ALARM does not set the flag again. A match on the wrap to zero counts as a match.
- R3: The tick flag (STATUS bit 1) sets on every tick, whether or not the alarm matched.
- R4: Both flags are sticky and are cleared only by writing a one to their bit of STATUS (address 2). A zero bit in the write leaves the flag unchanged. A set event in the same cycle as a clear wins.
- R5: A write to COUNT (address 0) is not applied at once. It loads into the counter on the third slow edge after the bus write. STATUS bit 2 reads 1 from the write until the load has been acknowledged back in the bus domain.
- R6: A COUNT write issued while STATUS bit 2 is 1 is discarded, and the earlier value is the one that loads.
- R7: A COUNT read returns the counter value as it stood after its latest increment or load, and never a mix of two values.
- R8: When a load and a tick fall on the same slow edge, the loaded value is kept without increment and no alarm compare is made. The tick flag still sets.
- R9: After the slow reset is released, the first tick ends on slow edge `DIV`, and later ticks follow every `DIV` slow edges.
- R10: Reset clears the flags, the enables, the pending state and the interrupt output. It does not change the counter or ALARM.
- R11: IRQEN (address 3) bit 0 enables the alarm flag and bit 1 enables the tick flag. The `irq` output is a registered OR of the enabled flags and reads back through IRQEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| clk_s | input | 1 | 32.768 kHz slow clock |
| rst_s | input | 1 | Synchronous active-high reset, slow domain |
| bus_addr | input | 2 | Register select: 0 COUNT, 1 ALARM, 2 STATUS, 3 IRQEN |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data for the address of the previous cycle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a counter load that lands on the same slow edge as a tick. That collision depends on the phase of the divider and on the latency of the synchronizer. The bench counts slow edges from the release of reset. It then issues the COUNT write in the slow cycle three edges ahead of a tick boundary, so that the load meets the increment. An alarm set to the loaded value shows that no compare was made. The dropped second write is forced in the same way, by issuing it while the pending bit is still set.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [1:0] {
    RA_COUNT  = 2'd0,
    RA_ALARM  = 2'd1,
    RA_STATUS = 2'd2,
    RA_IRQEN  = 2'd3
  } reg_e;

  localparam int ST_ALM  = 0;
  localparam int ST_TCK  = 1;
  localparam int ST_PEND = 2;
  localparam int NFLAG   = 2;
endpackage

// File: rtl/sec_sync.sv
module sec_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sec_tick_div.sv
module sec_tick_div #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);  // R9
endmodule

// File: rtl/sec_slow_core.sv
module sec_slow_core #(
  parameter int W = 32
) (
  input  logic         clk_s,
  input  logic         rst_s,
  input  logic         tick,
  input  logic         req_tgl,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] alarm_val,
  output logic [W-1:0] cnt,
  output logic         ack_tgl,
  output logic         upd_tgl,
  output logic         tck_tgl,
  output logic         alm_tgl
);
  logic         req_s;
  logic         req_seen;
  logic         ld;
  logic [W-1:0] nxt;

  sec_sync #(.W(1)) u_req (
    .clk (clk_s),
    .rst (rst_s),
    .d   (req_tgl),
    .q   (req_s)
  );

  assign ld      = req_s ^ req_seen;
  assign nxt     = cnt + 1'b1;
  assign ack_tgl = req_seen;

  // counter value is kept across reset
  always_ff @(posedge clk_s) begin
    if (ld)        cnt <= ld_val;
    else if (tick) cnt <= nxt;
  end

  always_ff @(posedge clk_s) begin
    if (rst_s) begin
      req_seen <= 1'b0;
      upd_tgl  <= 1'b0;
      tck_tgl  <= 1'b0;
      alm_tgl  <= 1'b0;
    end else begin
      if (ld)                          req_seen <= req_s;
      if (ld || tick)                  upd_tgl  <= ~upd_tgl;
      if (tick)                        tck_tgl  <= ~tck_tgl;
      if (tick && !ld && nxt == alarm_val) alm_tgl <= ~alm_tgl;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_s) disable iff (rst_s)
    (!ld && !tick) |=> $stable(cnt));  // R1
  AST_LOAD_WINS: assert property (@(posedge clk_s) disable iff (rst_s)
    (ld && tick) |=> (cnt == $past(ld_val)));  // R8
  AST_NO_CMP_ON_LOAD: assert property (@(posedge clk_s) disable iff (rst_s)
    ld |=> $stable(alm_tgl));  // R8
endmodule

// File: rtl/sec_alarm_ctr.sv
module sec_alarm_ctr #(
  parameter int W   = 32,
  parameter int DIV = 32768
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_s,
  input  logic         rst_s,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq
);
  import sec_pkg::*;

  localparam int NS = 4;

  logic               tick;
  logic [W-1:0]       cnt_s;
  logic               ack_t, upd_t, tck_t, alm_t;
  logic [NS-1:0]      bq, bq_d, edg;
  logic               req_tgl;
  logic [W-1:0]       ld_val;
  logic [W-1:0]       alarm_r;
  logic [W-1:0]       mirror;
  logic [NFLAG-1:0]   flg, en, set_ev;
  logic               pending;
  logic               wr_cnt, wr_alm, wr_st, wr_en;
  reg_e               ra;

  sec_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk_s),
    .rst  (rst_s),
    .tick (tick)
  );

  sec_slow_core #(.W(W)) u_core (
    .clk_s     (clk_s),
    .rst_s     (rst_s),
    .tick      (tick),
    .req_tgl   (req_tgl),
    .ld_val    (ld_val),
    .alarm_val (alarm_r),
    .cnt       (cnt_s),
    .ack_tgl   (ack_t),
    .upd_tgl   (upd_t),
    .tck_tgl   (tck_t),
    .alm_tgl   (alm_t)
  );

  sec_sync #(.W(NS)) u_bsync (
    .clk (clk),
    .rst (rst),
    .d   ({ack_t, upd_t, tck_t, alm_t}),
    .q   (bq)
  );

  assign edg     = bq ^ bq_d;
  assign pending = req_tgl ^ bq[3];
  assign set_ev[ST_ALM] = edg[0];
  assign set_ev[ST_TCK] = edg[1];

  assign ra     = reg_e'(bus_addr);
  assign wr_cnt = bus_we && (ra == RA_COUNT) && !pending;
  assign wr_alm = bus_we && (ra == RA_ALARM);
  assign wr_st  = bus_we && (ra == RA_STATUS);
  assign wr_en  = bus_we && (ra == RA_IRQEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      bq_d      <= '0;
      req_tgl   <= 1'b0;
      flg       <= '0;
      en        <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bq_d <= bq;
      if (wr_cnt) req_tgl <= ~req_tgl;
      if (wr_en)  en <= bus_wdata[NFLAG-1:0];
      for (int i = 0; i < NFLAG; i++)
        flg[i] <= (flg[i] & ~(wr_st & bus_wdata[i])) | set_ev[i];
      irq <= |(flg & en);
      case (ra)
        RA_COUNT:  bus_rdata <= mirror;
        RA_ALARM:  bus_rdata <= alarm_r;
        RA_STATUS: bus_rdata <= {{(W-3){1'b0}}, pending, flg};
        default:   bus_rdata <= {{(W-NFLAG){1'b0}}, en};
      endcase
    end
  end

  // values kept across reset
  always_ff @(posedge clk) begin
    if (wr_cnt) ld_val  <= bus_wdata;
    if (wr_alm) alarm_r <= bus_wdata;
    if (edg[2]) mirror  <= cnt_s;
  end

  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    (pending && bus_we && ra == RA_COUNT) |=> $stable(ld_val));  // R6
  AST_ALM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flg[ST_ALM] && !(wr_st && bus_wdata[ST_ALM])) |=> flg[ST_ALM]);  // R4
  AST_TCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flg[ST_TCK] && !(wr_st && bus_wdata[ST_TCK])) |=> flg[ST_TCK]);  // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);  // R11
endmodule

// File: tb/sim_sec_alarm_ctr.sv
module sim_sec_alarm_ctr;
  localparam int W   = 32;
  localparam int DIV = 8;

  localparam logic [2:0] OP_W = 3'd0;
  localparam logic [2:0] OP_R = 3'd1;
  localparam logic [2:0] OP_S = 3'd2;
  localparam logic [2:0] OP_I = 3'd3;
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_ALM = 2'd1;
  localparam logic [1:0] A_ST  = 2'd2;
  localparam logic [1:0] A_EN  = 2'd3;
  localparam logic [31:0] Z = 32'd0;
  localparam int NV = 54;

  // {op, addr, data, expected, requirement}
  localparam logic [73:0] VEC [NV] = '{
    {OP_S, A_CNT, 32'd1,   Z, 5'd0},
    {OP_W, A_ST,  32'd3,   Z, 5'd0},
    {OP_W, A_CNT, 32'd100, Z, 5'd0},
    {OP_R, A_ST,  Z, 32'd4,   5'd5},   // R5 pending visible
    {OP_W, A_CNT, 32'd555, Z, 5'd0},   // dropped
    {OP_S, A_CNT, 32'd6,   Z, 5'd0},
    {OP_R, A_ST,  Z, 32'd0,   5'd5},   // R5 pending cleared
    {OP_R, A_CNT, Z, 32'd100, 5'd6},   // R6
    {OP_S, A_CNT, 32'd1,   Z, 5'd0},
    {OP_R, A_CNT, Z, 32'd101, 5'd1},   // R1
    {OP_R, A_ST,  Z, 32'd2,   5'd3},   // R3
    {OP_W, A_ST,  32'd0,   Z, 5'd0},
    {OP_R, A_ST,  Z, 32'd2,   5'd4},   // R4 zero write
    {OP_W, A_ST,  32'd2,   Z, 5'd0},
    {OP_R, A_ST,  Z, 32'd0,   5'd4},   // R4 one clears
    {OP_W, A_ALM, 32'd103, Z, 5'd0},
    {OP_R, A_ALM, Z, 32'd103, 5'd2},   // R2
    {OP_S, A_CNT, 32'd1,   Z, 5'd0},
    {OP_R, A_CNT, Z, 32'd102, 5'd7},   // R7
    {OP_R, A_ST,  Z, 32'd2,   5'd2},   // R2 no match
    {OP_W, A_ST,  32'd3,   Z, 5'd0},
    {OP_S, A_CNT, 32'd1,   Z, 5'd0},
    {OP_R, A_ST,  Z, 32'd3,   5'd2},   // R2 match
    {OP_R, A_CNT, Z, 32'd103, 5'd7},   // R7
    {OP_W, A_EN,  32'd1,   Z, 5'd0},
    {OP_I, A_CNT, Z, 32'd1,   5'd11},  // R11
    {OP_W, A_ST,  32'd1,   Z, 5'd0},
    {OP_I, A_CNT, Z, 32'd0,   5'd11},  // R11
    {OP_W, A_EN,  32'd2,   Z, 5'd0},
    {OP_I, A_CNT, Z, 32'd1,   5'd11},  // R11
    {OP_R, A_EN,  Z, 32'd2,   5'd11},  // R11
    {OP_W, A_ST,  32'd2,   Z, 5'd0},
    {OP_I, A_CNT, Z, 32'd0,   5'd11},  // R11
    {OP_W, A_EN,  32'd0,   Z, 5'd0},
    {OP_S, A_CNT, 32'd1,   Z, 5'd0},
    {OP_R, A_ST,  Z, 32'd2,   5'd2},   // R2 no repeat match
    {OP_W, A_ST,  32'd3,   Z, 5'd0},
    {OP_W, A_ALM, 32'd200, Z, 5'd0},
    {OP_S, A_CNT, DIV - 3, Z, 5'd0},
    {OP_W, A_CNT, 32'd200, Z, 5'd0},   // load lands on tick
    {OP_S, A_CNT, 32'd2,   Z, 5'd0},
    {OP_R, A_CNT, Z, 32'd200, 5'd8},   // R8 no increment
    {OP_R, A_ST,  Z, 32'd2,   5'd8},   // R8 tick yes, alarm no
    {OP_W, A_ST,  32'd3,   Z, 5'd0},
    {OP_S, A_CNT, 32'd1,   Z, 5'd0},
    {OP_R, A_CNT, Z, 32'd201, 5'd1},   // R1
    {OP_W, A_CNT, 32'hFFFF_FFFF, Z, 5'd0},
    {OP_W, A_ALM, 32'd0,   Z, 5'd0},
    {OP_W, A_ST,  32'd3,   Z, 5'd0},
    {OP_S, A_CNT, 32'd6,   Z, 5'd0},
    {OP_R, A_CNT, Z, 32'hFFFF_FFFF, 5'd7}, // R7
    {OP_S, A_CNT, 32'd2,   Z, 5'd0},
    {OP_R, A_CNT, Z, 32'd0,   5'd1},   // R1 wrap
    {OP_R, A_ST,  Z, 32'd3,   5'd2}    // R2 match at wrap
  };

  logic         clk = 1'b0;
  logic         clk_s = 1'b0;
  logic         rst;
  logic [1:0]   bus_addr;
  logic         bus_we;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         irq;
  int           scnt = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #20 clk_s = ~clk_s;
  end

  always @(posedge clk_s) begin
    if (rst) scnt <= 0;
    else     scnt <= scnt + 1;
  end

  sec_alarm_ctr #(.W(W), .DIV(DIV)) u0 (
    .clk       (clk),
    .rst       (rst),
    .clk_s     (clk_s),
    .rst_s     (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input int req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_phase(input int p);
    do begin
      @(posedge clk_s);
      #1;
    end while (scnt % DIV != p);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_edge(input int n);
    do begin
      @(posedge clk_s);
      #1;
    end while (scnt != n);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] rd;
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk_s);
    @(negedge clk);
    rst = 1'b0;

    bus_rd(A_ST, rd); check(10, rd, 32'd0);      // R10 flags clear
    bus_rd(A_EN, rd); check(10, rd, 32'd0);      // R10 enables clear
    check(10, {31'd0, irq}, 32'd0);               // R10 irq low

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      case (v[73:71])
        OP_W: bus_wr(v[70:69], v[68:37]);
        OP_R: begin
          bus_rd(v[70:69], rd);
          check(int'(v[4:0]), rd, v[36:5]);
        end
        OP_S: wait_phase(int'(v[68:37]));
        default: begin
          @(negedge clk);
          @(negedge clk);
          check(int'(v[4:0]), {31'd0, irq}, v[36:5]);
        end
      endcase
    end

    // R10: reset keeps counter and alarm
    wait_phase(1);
    bus_wr(A_CNT, 32'h1234_5678);
    bus_wr(A_ALM, 32'hA5A5_A5A5);
    bus_wr(A_EN, 32'd3);
    wait_phase(6);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk_s);
    @(negedge clk);
    rst = 1'b0;
    bus_rd(A_CNT, rd); check(10, rd, 32'h1234_5678);  // R10
    bus_rd(A_ALM, rd); check(10, rd, 32'hA5A5_A5A5);  // R10
    bus_rd(A_ST, rd);  check(10, rd, 32'd0);          // R10
    bus_rd(A_EN, rd);  check(10, rd, 32'd0);          // R10
    check(10, {31'd0, irq}, 32'd0);                    // R10

    // R9: first tick exactly on slow edge DIV after reset release
    wait_edge(DIV - 1);
    bus_rd(A_ST, rd);  check(9, rd, 32'd0);           // R9 not yet
    bus_rd(A_CNT, rd); check(9, rd, 32'h1234_5678);   // R9
    wait_edge(DIV + 1);
    bus_rd(A_ST, rd);  check(9, rd, 32'd2);           // R9 tick seen
    bus_rd(A_CNT, rd); check(9, rd, 32'h1234_5679);   // R9

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule